// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This unit takes one IEEE-754 single-precision operand and, one clock later, returns a coarse estimate of 1/sqrt(x). Later Newton-Raphson steps refine this estimate; the unit does not refine it. The unit first sorts the operand into a class: NaN, zero or denormal, negative, positive infinity, or positive normal. Each special class returns a fixed encoding. A positive normal operand gets a computed result.

For a positive normal operand the result exponent comes from a halving subtraction on the biased exponent. The 8-bit significand comes from a fixed 128-entry table. The table is indexed by the parity of (E-1) and the six leading mantissa bits. An invalid indication goes out with every result, so the status logic can record it.

Top module: `rsqrt_seed`

## Requirements
- R1: `out_valid` rises exactly one clock after each `in_valid` cycle. `out_result` and `out_invalid` belong to that operand in that cycle. Without `in_valid`, `out_valid` stays low.
- R2: Any NaN operand returns 0x7FC00000. A NaN has exponent 0xFF, a nonzero mantissa, and either sign.
- R3: A zero or denormal operand (exponent 0) returns infinity with the operand's sign: 0x7F800000 for positive and 0xFF800000 for negative.
- R4: A negative operand that is neither NaN, zero nor denormal returns 0x7FC00004. This includes negative infinity.
- R5: Positive infinity (0x7F800000) returns 0x00000000.
- R6: A positive normal operand with biased exponent E gives sign 0 and exponent field 0xBD - ((E-1) >> 1).
- R7: For a positive normal operand, result bits 22..15 hold table[{(E-1) bit 0, operand bits 22..17}] and bits 14..0 are zero. The table has these properties:
  - Entry 2k holds an odd value v(k), and entry 2k+1 holds v(k)-1.
  - v(0) = 253 and v(63) = 3.
  - The table never increases with the index.
- R8: `out_invalid` is 1 for a signaling NaN (exponent 0xFF, mantissa nonzero, bit 22 clear) and for every R4 case. It is 0 for every other operand, including quiet NaNs.
- R9: A synchronous active-high reset clears `out_valid`, `out_result` and `out_invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Seed result |
| out_invalid | output | 1 | Invalid indication for this result |

## Verification
On every cycle, the assertions check these properties:
- The one-cycle valid latency.
- The invalid flag appears only alongside a result.
- The negative-operand NaN always carries invalid.
- Normal results have a clean low field and the copied sign.

The exact table contents, the exponent arithmetic and the per-class encodings need the bench's scoreboard. It sweeps all 128 table indices at both exponent parities, the extreme exponents, and every special class, and compares each result against an independent model.

// File: rtl/rsqrt_seed_pkg.sv
package rsqrt_seed_pkg;
  localparam int FP_W      = 32;
  localparam int EXP_W     = 8;
  localparam int MAN_W     = 23;
  localparam int IDX_MAN_W = 6;
  localparam int IDX_W     = IDX_MAN_W + 1;
  localparam int SIG_W     = 8;
  localparam int LOW_W     = MAN_W - SIG_W;

  localparam logic [EXP_W-1:0] EXP_BASE = 8'hBD;
  localparam logic [FP_W-1:0]  QNAN_RES = 32'h7FC0_0000;
  localparam logic [FP_W-1:0]  NEG_RES  = 32'h7FC0_0004;
  localparam logic [FP_W-1:0]  PINF_RES = 32'h7F80_0000;

  typedef enum logic [2:0] {
    CLS_NAN,
    CLS_ZERO,
    CLS_NEG,
    CLS_PINF,
    CLS_NORM
  } op_class_e;
endpackage

// File: rtl/rsqrt_seed_classify.sv
module rsqrt_seed_classify
  import rsqrt_seed_pkg::*;
(
  input  logic [FP_W-1:0] op,
  output op_class_e       cls,
  output logic            snan
);
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             ex_ones;

  assign sgn     = op[FP_W-1];
  assign ex      = op[FP_W-2 -: EXP_W];
  assign mn      = op[MAN_W-1:0];
  assign ex_ones = &ex;

  always_comb begin
    if (ex_ones && (mn != '0))      cls = CLS_NAN;
    else if (ex == '0)              cls = CLS_ZERO;
    else if (sgn)                   cls = CLS_NEG;
    else if (ex_ones)               cls = CLS_PINF;
    else                            cls = CLS_NORM;
  end

  assign snan = ex_ones && (mn != '0) && !mn[MAN_W-1];
endmodule

// File: rtl/rsqrt_seed_expcalc.sv
module rsqrt_seed_expcalc
  import rsqrt_seed_pkg::*;
(
  input  logic [EXP_W-1:0]     ex,
  input  logic [IDX_MAN_W-1:0] man_top,
  output logic [IDX_W-1:0]     idx,
  output logic [EXP_W-1:0]     res_exp
);
  logic [EXP_W-1:0] ex_m1;

  assign ex_m1   = ex - EXP_W'(1);
  assign idx     = {ex_m1[0], man_top};
  assign res_exp = EXP_BASE - {1'b0, ex_m1[EXP_W-1:1]};
endmodule

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom
  import rsqrt_seed_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-2:0] half;

  always_comb begin
    case (idx[IDX_W-1:1])
      6'd0:  half = 7'd126; 6'd1:  half = 7'd122; 6'd2:  half = 7'd119; 6'd3:  half = 7'd115;
      6'd4:  half = 7'd112; 6'd5:  half = 7'd108; 6'd6:  half = 7'd105; 6'd7:  half = 7'd102;
      6'd8:  half = 7'd100; 6'd9:  half = 7'd97;  6'd10: half = 7'd94;  6'd11: half = 7'd92;
      6'd12: half = 7'd89;  6'd13: half = 7'd87;  6'd14: half = 7'd84;  6'd15: half = 7'd82;
      6'd16: half = 7'd80;  6'd17: half = 7'd78;  6'd18: half = 7'd76;  6'd19: half = 7'd74;
      6'd20: half = 7'd72;  6'd21: half = 7'd70;  6'd22: half = 7'd68;  6'd23: half = 7'd66;
      6'd24: half = 7'd65;  6'd25: half = 7'd63;  6'd26: half = 7'd61;  6'd27: half = 7'd60;
      6'd28: half = 7'd58;  6'd29: half = 7'd57;  6'd30: half = 7'd55;  6'd31: half = 7'd54;
      6'd32: half = 7'd51;  6'd33: half = 7'd49;  6'd34: half = 7'd46;  6'd35: half = 7'd44;
      6'd36: half = 7'd41;  6'd37: half = 7'd39;  6'd38: half = 7'd37;  6'd39: half = 7'd35;
      6'd40: half = 7'd33;  6'd41: half = 7'd31;  6'd42: half = 7'd29;  6'd43: half = 7'd27;
      6'd44: half = 7'd26;  6'd45: half = 7'd24;  6'd46: half = 7'd22;  6'd47: half = 7'd21;
      6'd48: half = 7'd19;  6'd49: half = 7'd18;  6'd50: half = 7'd16;  6'd51: half = 7'd15;
      6'd52: half = 7'd13;  6'd53: half = 7'd12;  6'd54: half = 7'd11;  6'd55: half = 7'd9;
      6'd56: half = 7'd8;   6'd57: half = 7'd7;   6'd58: half = 7'd6;   6'd59: half = 7'd5;
      6'd60: half = 7'd4;   6'd61: half = 7'd3;   6'd62: half = 7'd2;   default: half = 7'd1;
    endcase
  end

  // R7: even entries odd, odd entries one less
  assign sig = {half, ~idx[0]};
endmodule

// File: rtl/rsqrt_seed.sv
module rsqrt_seed
  import rsqrt_seed_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_op,
  output logic            out_valid,
  output logic [31:0]     out_result,
  output logic            out_invalid
);
  op_class_e          cls;
  logic               snan;
  logic [IDX_W-1:0]   idx;
  logic [EXP_W-1:0]   res_exp;
  logic [SIG_W-1:0]   sig;
  logic [FP_W-1:0]    nxt_res;
  logic               nxt_inv;

  rsqrt_seed_classify u_cls (
    .op   (in_op),
    .cls  (cls),
    .snan (snan)
  );

  rsqrt_seed_expcalc u_exp (
    .ex      (in_op[FP_W-2 -: EXP_W]),
    .man_top (in_op[MAN_W-1 -: IDX_MAN_W]),
    .idx     (idx),
    .res_exp (res_exp)
  );

  rsqrt_seed_rom u_rom (
    .idx (idx),
    .sig (sig)
  );

  always_comb begin
    case (cls)
      CLS_NAN:  nxt_res = QNAN_RES;
      CLS_ZERO: nxt_res = {in_op[FP_W-1], PINF_RES[FP_W-2:0]};
      CLS_NEG:  nxt_res = NEG_RES;
      CLS_PINF: nxt_res = '0;
      default:  nxt_res = {in_op[FP_W-1], res_exp, sig, {LOW_W{1'b0}}};
    endcase
    nxt_inv = snan || (cls == CLS_NEG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_res;
        out_invalid <= nxt_inv;
      end else begin
        out_invalid <= 1'b0;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  p_inv_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_valid);

  p_neg_nan_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result == NEG_RES) |-> out_invalid);

  p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_NORM) |=> (out_result[LOW_W-1:0] == '0));

  p_sign_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_NORM) |=> (out_result[FP_W-1] == $past(in_op[FP_W-1])));
endmodule

// File: tb/sim_rsqrt_seed.sv
module sim_rsqrt_seed;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_op;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;

  always #2.5 clk = ~clk;

  rsqrt_seed u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid)
  );

  typedef struct {
    logic [31:0] res;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  int n_push = 0;
  int n_pop = 0;
  bit done = 0;

  localparam int unsigned ODDV [64] = '{
    253,245,239,231,225,217,211,205,201,195,189,185,179,175,169,165,
    161,157,153,149,145,141,137,133,131,127,123,121,117,115,111,109,
    103,99,93,89,83,79,75,71,67,63,59,55,53,49,45,43,
    39,37,33,31,27,25,23,19,17,15,13,11,9,7,5,3};

  function automatic int unsigned tab(input int unsigned i);
    return ODDV[i/2] - (i % 2);
  endfunction

  function automatic exp_t model(input logic [31:0] x, input string tag);
    exp_t e;
    int unsigned ex, m1;
    ex = x[30:23];
    e.tag = tag;
    e.inv = 1'b0;
    if (ex == 255 && x[22:0] != 0) begin
      e.res = 32'h7FC00000;
      e.inv = !x[22];
    end else if (ex == 0) begin
      e.res = {x[31], 31'h7F800000};
    end else if (x[31]) begin
      e.res = 32'h7FC00004;
      e.inv = 1'b1;
    end else if (ex == 255) begin
      e.res = 32'h0;
    end else begin
      m1 = ex - 1;
      e.res = 32'h0;
      e.res[30:23] = 8'(189 - m1 / 2);
      e.res[22:15] = 8'(tab((m1 % 2) * 64 + x[22:17]));
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] x, input string tag);
    q.push_back(model(x, tag));
    n_push++;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drive_burst(input logic [31:0] x, input string tag);
    q.push_back(model(x, tag));
    n_push++;
    in_valid = 1'b1;
    in_op    = x;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_pop++;
        check(out_result == e.res, e.tag, out_result, e.res);
        check(out_invalid == e.inv, {e.tag, " R8 invalid"}, 32'(out_invalid), 32'(e.inv));
      end
    end
  end

  initial begin
    #900000;
    check(1'b0, "R1 watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = 32'h0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R9 reset valid", 32'(out_valid), 0);
    check(out_result == 0, "R9 reset result", out_result, 0);
    check(out_invalid == 0, "R9 reset invalid", 32'(out_invalid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 0, "R1 idle no valid", 32'(out_valid), 0);

    // R7 all indices at both exponent parities (E=127 odd parity 0, E=128 parity 1)
    for (int i = 0; i < 64; i++) begin
      drive({1'b0, 8'd127, 6'(i), 17'h1ABCD}, "R7 table E=127");
      drive({1'b0, 8'd128, 6'(i), 17'h00000}, "R7 table E=128");
    end
    // R6 exponent extremes and spread
    drive({1'b0, 8'd1,   23'h7FFFFF}, "R6 exp E=1");
    drive({1'b0, 8'd2,   23'h000000}, "R6 exp E=2");
    drive({1'b0, 8'd253, 23'h123456}, "R6 exp E=253");
    drive({1'b0, 8'd254, 23'h7FFFFF}, "R6 exp E=254");
    drive(32'h3F800000, "R6 one");
    drive(32'h40800000, "R6 four");
    // specials
    drive(32'h7FC00000, "R2 qnan");
    drive(32'hFFC12345, "R2 neg qnan");
    drive(32'h7F800001, "R2 snan");
    drive(32'hFFA00000, "R2 neg snan");
    drive(32'h00000000, "R3 +zero");
    drive(32'h80000000, "R3 -zero");
    drive(32'h00400000, "R3 +denorm");
    drive(32'h807FFFFF, "R3 -denorm");
    drive(32'hBF800000, "R4 neg normal");
    drive(32'hFF800000, "R4 -inf");
    drive(32'h80800000, "R4 smallest neg normal");
    drive(32'h7F800000, "R5 +inf");
    // R1 back-to-back burst
    @(negedge clk);
    drive_burst(32'hBF000000, "R1 burst a");
    drive_burst(32'h41200000, "R1 burst b");
    drive_burst(32'h7F800002, "R1 burst c");
    drive_burst(32'h00000001, "R1 burst d");
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid drops", 32'(out_valid), 0);
    check(n_pop == n_push, "R1 result count", 32'(n_pop), 32'(n_push));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule